// File: doc/BRIEF.md
# Clustered Decode Block Steering Unit

This unit sits between a branch predictor and three parallel instruction decode clusters. The predictor delivers fetch blocks. Each block gives a start address and the number of instructions up to the next predicted-taken branch. The unit forwards each block to a cluster. Consecutive pieces of work go to clusters in a fixed rotation, so that up to three predicted targets are being decoded at the same time.

A branch-free run longer than the per-cluster queue limit (32 instructions by default) is cut at artificial boundaries into chunks of at most 32 instructions. These chunks are dealt through the same rotation, so the clusters leapfrog one another through a long run. A chunk is described by:
- the block start address;
- the instruction index within the block at which the chunk begins;
- its instruction count;
- a last-chunk flag;
- a sequence tag that increases by one per chunk, so that decoded output can be put back in program order.

Control is a two-state machine. In **Idle**, no block is held and the input is ready. In **Emit**, a block is held and its current chunk is offered to the cluster whose turn it is. The transitions are:
- **accept** (Idle to Emit): a block with a nonzero count is taken.
- **advance** (Emit to Emit): a non-final chunk is handed off.
- **reload** (Emit to Emit): the final chunk is handed off and a new nonzero block is taken in the same cycle.
- **drain** (Emit to Idle): the final chunk is handed off and no new nonzero block is taken.
- **flush** (any state to Idle): the flush input is high.

Top module: `decode_steer`

## Requirements
- R1: Exactly one cluster is due at any time. Chunks are offered only to the due cluster, with clusters numbered 0, 1, 2. Each handed-off chunk moves the due cluster on in the order 0, 1, 2, 0, and so on, whether or not the chunk ends a block.
- R2: Every chunk carries the start address of its block unchanged. It also carries the instruction offset of its first instruction within the block, which is 0 for the first chunk and grows by 32 per chunk.
- R3: A block of N instructions yields ceil(N/32) chunks. Every chunk except the final one has a count of 32, and the final chunk has the remainder (32 if N is a multiple of 32). A 32-instruction block gives one chunk; a 33-instruction block gives chunks of 32 and 1. The last flag is 1 only on the final chunk.
- R4: The sequence tag of a chunk is one more than that of the previous handed-off chunk, modulo 2^TAG_W (16 by default), so it wraps from 15 to 0.
- R5: While the due cluster's ready is low, its chunk stays valid with every field unchanged. No other cluster is offered anything, the rotation is not advanced, and in_ready is low.
- R6: While flush is high, in_ready and every out_valid are low. On the following cycle no chunk is offered: the held block is discarded and the due cluster and the tag are both 0, so the next chunk goes to cluster 0 with tag 0.
- R7: With all clusters ready, one chunk is handed off per cycle. in_ready is high in Idle, and in Emit together with the hand-off of a final chunk. A block accepted in either case is offered on the very next cycle.
- R8: A block with a count of 0 is accepted and yields no chunk. The rotation and the tag are left as they were.
- R9: During and right after reset, no out_valid is high, in_ready is high, and the due cluster and the tag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard held block, return rotation and tag to zero |
| in_valid | input | 1 | Fetch block offered |
| in_ready | output | 1 | Fetch block taken when in_valid is also high |
| in_addr | input | ADDR_W | Start address of the block |
| in_count | input | CNT_W | Instruction count up to the predicted-taken branch |
| out_valid | output | N_CLUST | Chunk offered, one bit per cluster |
| out_ready | input | N_CLUST | Cluster can take a chunk, one bit per cluster |
| out_addr | output | N_CLUST x ADDR_W | Block start address for each cluster |
| out_offset | output | N_CLUST x CNT_W | Instruction offset of chunk within its block |
| out_count | output | N_CLUST x clog2(CHUNK_MAX+1) | Instructions in the chunk |
| out_last | output | N_CLUST | Chunk ends its block |
| out_tag | output | N_CLUST x TAG_W | Sequence tag |

## Verification
The hardest case to reach from the ports is a flush that arrives while a long block is part-way through splitting and the due cluster is holding it back. In that state the held remainder, a nonzero rotation pointer and a nonzero tag must all be dropped together. The stimulus reaches this case directly: it stalls all clusters, feeds in a 100-instruction block, and then pulses flush. In a long random phase, ready patterns change every cycle and flushes are sprinkled throughout, so flushes also land in the middle of splits, on reload cycles and on zero-count blocks. Tag wrap is reached by streaming more than sixteen chunks.

// File: rtl/steer_pkg.sv
package steer_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } steer_state_e;

endpackage

// File: rtl/steer_fsm.sv
module steer_fsm
    import steer_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         in_valid,
    input  logic         blk_nonzero,
    input  logic         ready_sel,
    input  logic         chunk_last,
    output steer_state_e state,
    output logic         in_ready,
    output logic         load,
    output logic         emit_valid,
    output logic         fire
);

    steer_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // outputs
    always_comb begin
        emit_valid = 1'b0;
        in_ready   = 1'b0;
        unique case (state)
            ST_IDLE: in_ready = !flush;
            ST_EMIT: begin
                emit_valid = !flush;
                in_ready   = !flush && ready_sel && chunk_last;
            end
        endcase
    end

    assign fire = emit_valid && ready_sel;
    assign load = in_valid && in_ready;

    // transitions: accept, advance, reload, drain, flush
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: if (load && blk_nonzero) state_d = ST_EMIT;
            ST_EMIT: if (fire && chunk_last)
                         state_d = (load && blk_nonzero) ? ST_EMIT : ST_IDLE;
        endcase
        if (flush) state_d = ST_IDLE;
    end

endmodule

// File: rtl/steer_chunker.sv
module steer_chunker #(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 8,
    parameter int CHUNK_MAX = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               flush,
    input  logic                               load,
    input  logic                               fire,
    input  logic [ADDR_W-1:0]                  in_addr,
    input  logic [CNT_W-1:0]                   in_count,
    output logic [ADDR_W-1:0]                  blk_addr,
    output logic [CNT_W-1:0]                   blk_off,
    output logic [$clog2(CHUNK_MAX+1)-1:0]     chunk_cnt,
    output logic                               chunk_last
);

    localparam int CHK_W = $clog2(CHUNK_MAX + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CHUNK_MAX);

    logic [CNT_W-1:0] remain;

    assign chunk_last = (remain <= LIMIT);
    assign chunk_cnt  = chunk_last ? remain[CHK_W-1:0] : CHK_W'(CHUNK_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_addr <= '0;
            blk_off  <= '0;
            remain   <= '0;
        end else if (flush) begin
            blk_off  <= '0;
            remain   <= '0;
        end else if (load) begin
            blk_addr <= in_addr;
            blk_off  <= '0;
            remain   <= in_count;
        end else if (fire) begin
            remain   <= remain - CNT_W'(chunk_cnt);
            blk_off  <= blk_off + LIMIT;
        end
    end

endmodule

// File: rtl/steer_rotor.sv
module steer_rotor #(
    parameter int N_CLUST = 3,
    parameter int TAG_W   = 4
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         flush,
    input  logic                                         fire,
    output logic [((N_CLUST > 1) ? $clog2(N_CLUST) : 1)-1:0] ptr,
    output logic [TAG_W-1:0]                             tag
);

    localparam int PTR_W = (N_CLUST > 1) ? $clog2(N_CLUST) : 1;
    localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(N_CLUST - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
            tag <= '0;
        end else if (flush) begin
            ptr <= '0;
            tag <= '0;
        end else if (fire) begin
            ptr <= (ptr == PTR_TOP) ? '0 : ptr + 1'b1;
            tag <= tag + 1'b1;
        end
    end

endmodule

// File: rtl/decode_steer.sv
module decode_steer
    import steer_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 8,
    parameter int CHUNK_MAX = 32,
    parameter int TAG_W     = 4,
    parameter int N_CLUST   = 3
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic                                            flush,
    input  logic                                            in_valid,
    output logic                                            in_ready,
    input  logic [ADDR_W-1:0]                               in_addr,
    input  logic [CNT_W-1:0]                                in_count,
    output logic [N_CLUST-1:0]                              out_valid,
    input  logic [N_CLUST-1:0]                              out_ready,
    output logic [N_CLUST-1:0][ADDR_W-1:0]                  out_addr,
    output logic [N_CLUST-1:0][CNT_W-1:0]                   out_offset,
    output logic [N_CLUST-1:0][$clog2(CHUNK_MAX+1)-1:0]     out_count,
    output logic [N_CLUST-1:0]                              out_last,
    output logic [N_CLUST-1:0][TAG_W-1:0]                   out_tag
);

    localparam int PTR_W = (N_CLUST > 1) ? $clog2(N_CLUST) : 1;
    localparam int CHK_W = $clog2(CHUNK_MAX + 1);

    steer_state_e        state;
    logic                emit_valid;
    logic                fire;
    logic                load;
    logic                ready_sel;
    logic                chunk_last;
    logic [CHK_W-1:0]    chunk_cnt;
    logic [ADDR_W-1:0]   blk_addr;
    logic [CNT_W-1:0]    blk_off;
    logic [PTR_W-1:0]    ptr;
    logic [TAG_W-1:0]    tag;
    logic [N_CLUST-1:0]  sel_oh;

    steer_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .in_valid    (in_valid),
        .blk_nonzero (in_count != '0),
        .ready_sel   (ready_sel),
        .chunk_last  (chunk_last),
        .state       (state),
        .in_ready    (in_ready),
        .load        (load),
        .emit_valid  (emit_valid),
        .fire        (fire)
    );

    steer_chunker #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .CHUNK_MAX (CHUNK_MAX)
    ) u_chunker (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .load       (load),
        .fire       (fire),
        .in_addr    (in_addr),
        .in_count   (in_count),
        .blk_addr   (blk_addr),
        .blk_off    (blk_off),
        .chunk_cnt  (chunk_cnt),
        .chunk_last (chunk_last)
    );

    steer_rotor #(
        .N_CLUST (N_CLUST),
        .TAG_W   (TAG_W)
    ) u_rotor (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .fire  (fire),
        .ptr   (ptr),
        .tag   (tag)
    );

    // per-cluster lanes: shared chunk fields, valid qualified by the rotation
    for (genvar c = 0; c < N_CLUST; c++) begin : g_lane
        assign sel_oh[c]     = (ptr == PTR_W'(c));
        assign out_valid[c]  = emit_valid && sel_oh[c];
        assign out_addr[c]   = blk_addr;
        assign out_offset[c] = blk_off;
        assign out_count[c]  = chunk_cnt;
        assign out_last[c]   = chunk_last;
        assign out_tag[c]    = tag;
    end

    assign ready_sel = |(out_ready & sel_oh);

endmodule

// File: rtl/steer_checker.sv
module steer_checker #(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 8,
    parameter int CHUNK_MAX = 32,
    parameter int TAG_W     = 4,
    parameter int N_CLUST   = 3
) (
    input logic                                        clk,
    input logic                                        rst_n,
    input logic                                        flush,
    input logic                                        in_ready,
    input logic [N_CLUST-1:0]                          out_valid,
    input logic [N_CLUST-1:0]                          out_ready,
    input logic [N_CLUST-1:0][ADDR_W-1:0]              out_addr,
    input logic [N_CLUST-1:0][CNT_W-1:0]               out_offset,
    input logic [N_CLUST-1:0][$clog2(CHUNK_MAX+1)-1:0] out_count,
    input logic [N_CLUST-1:0][TAG_W-1:0]               out_tag
);

    localparam int PTR_W = (N_CLUST > 1) ? $clog2(N_CLUST) : 1;
    localparam int CHK_W = $clog2(CHUNK_MAX + 1);

    logic             any_fire;
    logic [PTR_W-1:0] exp_ptr;
    logic [TAG_W-1:0] exp_tag;

    assign any_fire = |(out_valid & out_ready);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_ptr <= '0;
            exp_tag <= '0;
        end else if (flush) begin
            exp_ptr <= '0;
            exp_tag <= '0;
        end else if (any_fire) begin
            exp_ptr <= (exp_ptr == PTR_W'(N_CLUST - 1)) ? '0 : exp_ptr + 1'b1;
            exp_tag <= exp_tag + 1'b1;
        end
    end

    assert_single_due_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid));

    assert_flush_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!in_ready && out_valid == '0));

    assert_flush_after_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (out_valid == '0));

    for (genvar c = 0; c < N_CLUST; c++) begin : g_chk
        assert_rotation_R1: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[c] |-> (exp_ptr == PTR_W'(c)));

        assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[c] |-> (out_count[c] != '0 && out_count[c] <= CHK_W'(CHUNK_MAX)));

        assert_tag_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[c] && out_ready[c]) |-> (out_tag[c] == exp_tag));

        assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[c] && !out_ready[c] && !flush) |=>
                (flush || (out_valid[c] && $stable(out_addr[c]) &&
                 $stable(out_offset[c]) && $stable(out_count[c]) &&
                 $stable(out_tag[c]))));

        assert_stall_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[c] && !out_ready[c]) |-> !in_ready);
    end

endmodule

bind decode_steer steer_checker #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .CHUNK_MAX (CHUNK_MAX),
    .TAG_W     (TAG_W),
    .N_CLUST   (N_CLUST)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_addr   (out_addr),
    .out_offset (out_offset),
    .out_count  (out_count),
    .out_tag    (out_tag)
);

// File: tb/decode_steer_tb_top.sv
`timescale 1ns/1ps
module decode_steer_tb_top;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 8;
    localparam int CMAX   = 32;
    localparam int TAG_W  = 4;
    localparam int NC     = 3;
    localparam int CHK_W  = $clog2(CMAX + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [CNT_W-1:0]  in_count = '0;
    logic [NC-1:0]     out_valid;
    logic [NC-1:0]     out_ready = '1;
    logic [NC-1:0][ADDR_W-1:0] out_addr;
    logic [NC-1:0][CNT_W-1:0]  out_offset;
    logic [NC-1:0][CHK_W-1:0]  out_count;
    logic [NC-1:0]             out_last;
    logic [NC-1:0][TAG_W-1:0]  out_tag;

    always #2 clk = ~clk;

    decode_steer dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_count(in_count),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_offset(out_offset),
        .out_count(out_count), .out_last(out_last), .out_tag(out_tag)
    );

    typedef struct {
        logic [ADDR_W-1:0] addr;
        int                off;
        int                cnt;
        bit                last;
    } chunk_t;

    chunk_t q[$];
    int m_ptr = 0;
    int m_tag = 0;
    int n_tests = 0;
    int n_fail = 0;
    bit rnd_mode = 0;
    bit done = 0;

    task automatic chk(string req, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model, compared every cycle at the falling edge
    always @(negedge clk) begin
        bit exp_rdy;
        bit ev;
        int rem;
        int off;
        chunk_t ch;
        if (!rst_n) begin
            q.delete();
            m_ptr = 0;
            m_tag = 0;
        end else if (!done) begin
            exp_rdy = !flush && (q.size() == 0 || (q.size() == 1 && out_ready[m_ptr]));
            chk("R5 R6 R7 in_ready", in_ready, exp_rdy);
            for (int c = 0; c < NC; c++) begin
                ev = !flush && q.size() > 0 && c == m_ptr;
                chk("R1 R5 R6 out_valid", out_valid[c], ev);
                if (ev) begin
                    chk("R2 addr", out_addr[c], q[0].addr);
                    chk("R2 offset", out_offset[c], q[0].off);
                    chk("R3 count", out_count[c], q[0].cnt);
                    chk("R3 last", out_last[c], q[0].last);
                    chk("R4 tag", out_tag[c], m_tag);
                end
            end
            if (flush) begin
                q.delete();
                m_ptr = 0;
                m_tag = 0;
            end else begin
                if (q.size() > 0 && out_ready[m_ptr]) begin
                    void'(q.pop_front());
                    m_ptr = (m_ptr + 1) % NC;
                    m_tag = (m_tag + 1) % (1 << TAG_W);
                end
                if (in_valid && exp_rdy) begin
                    rem = int'(in_count);
                    off = 0;
                    while (rem > 0) begin
                        ch.addr = in_addr;
                        ch.off  = off;
                        ch.cnt  = (rem > CMAX) ? CMAX : rem;
                        ch.last = (rem <= CMAX);
                        q.push_back(ch);
                        rem -= ch.cnt;
                        off += CMAX;
                    end
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        if (rnd_mode) begin
            out_ready = NC'($urandom);
            flush = ($urandom_range(0, 40) == 0);
        end
    endtask

    task automatic send(logic [ADDR_W-1:0] a, int n);
        bit acc;
        in_valid = 1'b1;
        in_addr  = a;
        in_count = CNT_W'(n);
        acc = 1'b0;
        while (!acc) begin
            @(negedge clk);
            acc = in_ready;
            tick();
        end
        in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && out_valid != '0; i++) tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 in_ready in reset", in_ready, 1);
        chk("R9 out_valid in reset", out_valid, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R9 out_valid after reset", out_valid, 0);
        tick();

        // R1 R7: short blocks back to back
        send(32'h1000, 5);
        send(32'h2000, 7);
        send(32'h3000, 3);
        send(32'h4000, 20);
        // R3 boundaries
        send(32'h5000, 32);
        send(32'h6000, 33);
        send(32'h7000, 100);
        send(32'h8000, 64);
        drain();

        // R8: zero-count block
        send(32'h9000, 0);
        chk("R8 no chunk", out_valid, 0);
        chk("R8 ready", in_ready, 1);
        send(32'h9100, 2);
        drain();

        // R5: stall on the due cluster
        out_ready = '0;
        send(32'hA000, 70);
        repeat (4) tick();
        chk("R5 held", out_valid != 0, 1);
        out_ready = 3'b101;
        repeat (4) tick();
        out_ready = '1;
        drain();

        // R6: flush mid-split under backpressure
        out_ready = '0;
        send(32'hB000, 100);
        repeat (2) tick();
        flush = 1'b1;
        tick();
        flush = 1'b0;
        chk("R6 nothing after flush", out_valid, 0);
        out_ready = '1;
        send(32'hC000, 10);
        chk("R6 cluster0 after flush", out_valid, 3'b001);
        chk("R6 tag0 after flush", out_tag[0], 0);
        drain();

        // R4: tag wrap over many chunks
        for (int i = 0; i < 12; i++) send(32'hD000 + 32'(i), 40);
        drain();

        // random phase
        rnd_mode = 1;
        for (int i = 0; i < 150; i++)
            send($urandom, $urandom_range(0, 200));
        rnd_mode = 0;
        flush = 1'b0;
        out_ready = '1;
        drain();
        tick();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule